// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block takes an Ethernet PHY at a known management address through reset and auto-negotiation, with no software involved. A single start strobe begins the sequence. The block issues register reads and writes one at a time through an external management frame master, using a request/acknowledge handshake. It waits on a slow 500 ms tick between polls, so it keeps no wall-clock counter of its own.

The sequence has a fixed order. It resets the PHY and polls until the reset bit self-clears. It captures the vendor status-output register and programs the vendor interrupt mask. It then turns the PHY's capability bits into an advertisement word and restarts negotiation. Finally it polls for completion, restarting negotiation whenever the link partner reports a remote fault. At the end it sets speed and duplex from the captured vendor status, sets a failed flag when the sequence did not succeed, and pulses done.

Top module: `phy_aneg_seq`

## Requirements
- R1: After reset, speed, duplex, failed and done are 0 and no management request is raised. A start strobe seen while a sequence is running has no effect.
- R2: Each management request stays high with a stable write flag, register number, data and PHY address until the cycle mgmt_ack is high. The PHY address is the value of phy_addr in the start cycle.
- R3: The first access writes register 0 with 16'h8000. Register 0 is then read. A read with bit 15 still set is repeated only after the next tick, and no more than RST_TRIES (6) reads are made.
- R4: If all RST_TRIES reads of register 0 show bit 15 set, the sequence ends with failed=1, speed=0 and duplex=0, and makes no further access.
- R5: After the reset clears, the accesses come in this order: read register 18, write register 19 with IRQ_MASK, read register 1, write register 4, write register 0 with 16'h1200 (bit 12 enable, bit 9 restart).
- R6: The register-4 word is 16'h0001 plus bits 9..5. These are set from register-1 bits 15..11 as follows: 15→9, 14→8, 13→7, 12→6, 11→5.
- R7: Register 1 is then polled for bit 5 (complete). A repeat read waits for the next tick, and at most ANEG_TRIES (20) polls are made. If the last allowed poll is still incomplete, failed=1.
- R8: If an incomplete poll shows bit 4 (remote fault), then after the next tick register 0 is written with 16'h3300 before the following poll.
- R9: When a poll shows bit 5 set, the sequence ends. failed equals bit 4 of that same read.
- R10: At the end of every sequence, done is high for exactly one cycle. In a sequence that passed reset, speed and duplex then equal bits 7 and 6 of the register-18 value. speed, duplex and failed change only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence (used only when idle) |
| phy_addr | input | 5 | Management address of the PHY, captured at start |
| tick | input | 1 | One-cycle pulse every 500 ms |
| mgmt_ack | input | 1 | Frame master has finished the current access |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_ack |
| mgmt_req | output | 1 | Access request, held until acknowledged |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_phy | output | 5 | PHY address of the access |
| mgmt_reg | output | 5 | Register number of the access |
| mgmt_wdata | output | 16 | Write data |
| speed | output | 1 | 1 = 100 Mb/s detected |
| duplex | output | 1 | 1 = full duplex detected |
| failed | output | 1 | Last sequence did not succeed |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume a frame master that raises mgmt_ack for a single cycle, and only while mgmt_req is high. They also assume that tick is a one-cycle pulse. The bench's PHY model answers each request after a fixed latency with a one-cycle acknowledge and then waits for the next request. Its tick generator makes isolated single-cycle pulses. Start is pulsed for one cycle, including once in the middle of a running sequence, so that the ignore rule is exercised without breaking the handshake assumptions.

// File: rtl/phy_aneg_pkg.sv
package phy_aneg_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 16;

  localparam logic [ADDR_W-1:0] RN_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] RN_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] RN_ADV  = 5'd4;
  localparam logic [ADDR_W-1:0] RN_IRQ  = 5'd18;
  localparam logic [ADDR_W-1:0] RN_MASK = 5'd19;

  localparam logic [WORD_W-1:0] CTRL_RESET   = 16'h8000;
  localparam logic [WORD_W-1:0] CTRL_RESTART = 16'h1200;
  localparam logic [WORD_W-1:0] CTRL_FORCED  = 16'h3300;

  localparam int BIT_RST_BUSY = 15;
  localparam int BIT_COMPLETE = 5;
  localparam int BIT_FAULT    = 4;
  localparam int BIT_SPD_DET  = 7;
  localparam int BIT_DPX_DET  = 6;
  localparam int TECH_N       = 5;
  localparam int CAP_LSB      = 11;
  localparam int ADV_LSB      = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_WR, ST_RST_RD, ST_RST_WAIT, ST_IRQ_RD, ST_MASK_WR,
    ST_CAP_RD, ST_ADV_WR, ST_ANEG_WR, ST_POLL_RD, ST_POLL_WAIT, ST_FLT_WR
  } seq_state_t;

  typedef struct packed {
    logic                wr;
    logic [ADDR_W-1:0]   regno;
    logic [WORD_W-1:0]   wdata;
  } mgmt_cmd_t;
endpackage

// File: rtl/phy_aneg_adv.sv
module phy_aneg_adv
  import phy_aneg_pkg::*;
(
  input  logic [TECH_N-1:0] tech_caps,
  output logic [WORD_W-1:0] adv_word
);
  always_comb begin
    adv_word    = '0;
    adv_word[0] = 1'b1;
    for (int i = 0; i < TECH_N; i++) begin
      adv_word[ADV_LSB+i] = tech_caps[i];
    end
  end
endmodule

// File: rtl/phy_aneg_retry.sv
module phy_aneg_retry #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  assert_retry_bound_R3: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last);
endmodule

// File: rtl/phy_aneg_req.sv
module phy_aneg_req
  import phy_aneg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  mgmt_cmd_t         cmd,
  input  logic [ADDR_W-1:0] phy_in,
  input  logic              ack,
  output logic              req,
  output logic              wr,
  output logic [ADDR_W-1:0] phy,
  output logic [ADDR_W-1:0] regno,
  output logic [WORD_W-1:0] wdata
);
  mgmt_cmd_t         cmd_q;
  logic [ADDR_W-1:0] phy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      cmd_q <= '0;
      phy_q <= '0;
    end else if (go) begin
      req   <= 1'b1;
      cmd_q <= cmd;
      phy_q <= phy_in;
    end else if (ack) begin
      req   <= 1'b0;
    end
  end

  assign wr    = cmd_q.wr;
  assign regno = cmd_q.regno;
  assign wdata = cmd_q.wdata;
  assign phy   = phy_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(cmd_q) && $stable(phy_q)));
endmodule

// File: rtl/phy_aneg_seq.sv
module phy_aneg_seq
  import phy_aneg_pkg::*;
#(
  parameter int                RST_TRIES  = 6,
  parameter int                ANEG_TRIES = 20,
  parameter logic [WORD_W-1:0] IRQ_MASK   = 16'h7F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              tick,
  input  logic              mgmt_ack,
  input  logic [WORD_W-1:0] mgmt_rdata,
  output logic              mgmt_req,
  output logic              mgmt_wr,
  output logic [ADDR_W-1:0] mgmt_phy,
  output logic [ADDR_W-1:0] mgmt_reg,
  output logic [WORD_W-1:0] mgmt_wdata,
  output logic              speed,
  output logic              duplex,
  output logic              failed,
  output logic              done
);
  seq_state_t        state;
  logic              pend;
  logic [ADDR_W-1:0] phy_q;
  logic [1:0]        det_q;
  logic [TECH_N-1:0] caps_q;
  logic              flt_q;
  logic [WORD_W-1:0] adv_word;
  mgmt_cmd_t         cmd;
  logic              access, go;
  logic              rst_last, poll_last, rst_inc, poll_inc, cnt_clr;
  logic              rd_busy, rd_cmpl, rd_flt;
  logic              unused_rdata;

  assign unused_rdata = ^{mgmt_rdata[10:8], mgmt_rdata[3:0]};
  assign rd_busy = mgmt_rdata[BIT_RST_BUSY];
  assign rd_cmpl = mgmt_rdata[BIT_COMPLETE];
  assign rd_flt  = mgmt_rdata[BIT_FAULT];

  phy_aneg_adv u_adv (.tech_caps(caps_q), .adv_word(adv_word));

  always_comb begin
    cmd = '0;
    unique case (state)
      ST_RST_WR:  cmd = '{wr: 1'b1, regno: RN_CTRL, wdata: CTRL_RESET};
      ST_RST_RD:  cmd = '{wr: 1'b0, regno: RN_CTRL, wdata: '0};
      ST_IRQ_RD:  cmd = '{wr: 1'b0, regno: RN_IRQ,  wdata: '0};
      ST_MASK_WR: cmd = '{wr: 1'b1, regno: RN_MASK, wdata: IRQ_MASK};
      ST_CAP_RD:  cmd = '{wr: 1'b0, regno: RN_STAT, wdata: '0};
      ST_ADV_WR:  cmd = '{wr: 1'b1, regno: RN_ADV,  wdata: adv_word};
      ST_ANEG_WR: cmd = '{wr: 1'b1, regno: RN_CTRL, wdata: CTRL_RESTART};
      ST_POLL_RD: cmd = '{wr: 1'b0, regno: RN_STAT, wdata: '0};
      ST_FLT_WR:  cmd = '{wr: 1'b1, regno: RN_CTRL, wdata: CTRL_FORCED};
      default:    cmd = '0;
    endcase
  end

  assign access   = !(state inside {ST_IDLE, ST_RST_WAIT, ST_POLL_WAIT});
  assign go       = access && !pend;
  assign cnt_clr  = (state == ST_IDLE);
  assign rst_inc  = (state == ST_RST_RD)  && mgmt_ack && rd_busy && !rst_last;
  assign poll_inc = (state == ST_POLL_RD) && mgmt_ack && !rd_cmpl && !poll_last;

  phy_aneg_retry #(.LIMIT(RST_TRIES)) u_rst_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(rst_inc), .last(rst_last));

  phy_aneg_retry #(.LIMIT(ANEG_TRIES)) u_poll_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(poll_inc), .last(poll_last));

  phy_aneg_req u_req (
    .clk(clk), .rst(rst), .go(go), .cmd(cmd), .phy_in(phy_q), .ack(mgmt_ack),
    .req(mgmt_req), .wr(mgmt_wr), .phy(mgmt_phy), .regno(mgmt_reg),
    .wdata(mgmt_wdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      phy_q  <= '0;
      det_q  <= '0;
      caps_q <= '0;
      flt_q  <= 1'b0;
      speed  <= 1'b0;
      duplex <= 1'b0;
      failed <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go)       pend <= 1'b1;
      if (mgmt_ack) pend <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          phy_q <= phy_addr;
          state <= ST_RST_WR;
        end
        ST_RST_WR:   if (mgmt_ack) state <= ST_RST_RD;
        ST_RST_RD: if (mgmt_ack) begin
          if (!rd_busy) state <= ST_IRQ_RD;
          else if (rst_last) begin
            state  <= ST_IDLE;
            speed  <= 1'b0;
            duplex <= 1'b0;
            failed <= 1'b1;
            done   <= 1'b1;
          end else state <= ST_RST_WAIT;
        end
        ST_RST_WAIT: if (tick) state <= ST_RST_RD;
        ST_IRQ_RD: if (mgmt_ack) begin
          det_q <= {mgmt_rdata[BIT_SPD_DET], mgmt_rdata[BIT_DPX_DET]};
          state <= ST_MASK_WR;
        end
        ST_MASK_WR: if (mgmt_ack) state <= ST_CAP_RD;
        ST_CAP_RD: if (mgmt_ack) begin
          caps_q <= mgmt_rdata[CAP_LSB +: TECH_N];
          state  <= ST_ADV_WR;
        end
        ST_ADV_WR:  if (mgmt_ack) state <= ST_ANEG_WR;
        ST_ANEG_WR: if (mgmt_ack) state <= ST_POLL_RD;
        ST_POLL_RD: if (mgmt_ack) begin
          flt_q <= rd_flt;
          if (rd_cmpl || poll_last) begin
            state  <= ST_IDLE;
            speed  <= det_q[1];
            duplex <= det_q[0];
            failed <= rd_cmpl ? rd_flt : 1'b1;
            done   <= 1'b1;
          end else state <= ST_POLL_WAIT;
        end
        ST_POLL_WAIT: if (tick) state <= flt_q ? ST_FLT_WR : ST_POLL_RD;
        ST_FLT_WR:    if (mgmt_ack) state <= ST_POLL_RD;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mgmt_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({speed, duplex, failed}));
endmodule

// File: tb/test_phy_aneg_seq.sv
module test_phy_aneg_seq;
  localparam int          CLK_PERIOD = 10;
  localparam int          LAT        = 3;
  localparam int          TICK_GAP   = 20;
  localparam logic [15:0] MASK_EXP   = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic        tick = 1'b0;
  logic        mgmt_ack = 1'b0;
  logic [15:0] mgmt_rdata = '0;
  logic        mgmt_req, mgmt_wr;
  logic [4:0]  mgmt_phy, mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        speed, duplex, failed, done;

  phy_aneg_seq #(.RST_TRIES(6), .ANEG_TRIES(20), .IRQ_MASK(MASK_EXP)) i_phy_aneg_seq (
    .clk(clk), .rst(rst), .start(start), .phy_addr(phy_addr), .tick(tick),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata), .mgmt_req(mgmt_req),
    .mgmt_wr(mgmt_wr), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
    .mgmt_wdata(mgmt_wdata), .speed(speed), .duplex(duplex),
    .failed(failed), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // PHY model state
  int          rst_busy_reads;
  logic [15:0] m_irq, m_caps;
  logic [15:0] poll_seq [0:31];
  int          n_rst_reads, stat_reads, n_ops, n_w4, n_w8000, n_w3300, addr_err, done_cnt;
  logic [4:0]  exp_addr;
  logic [5:0]  op_log [0:63];
  logic [15:0] last_w [0:31];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_model();
    rst_busy_reads = 1; m_irq = 16'h00C0; m_caps = 16'hF800;
    for (int i = 0; i < 32; i++) begin poll_seq[i] = 16'h0020; last_w[i] = '0; end
    n_rst_reads = 0; stat_reads = 0; n_ops = 0; n_w4 = 0; n_w8000 = 0;
    n_w3300 = 0; addr_err = 0; done_cnt = 0;
  endtask

  // management PHY model
  initial begin
    forever begin
      @(negedge clk);
      if (mgmt_req) begin
        if (mgmt_phy != exp_addr) addr_err++;
        if (n_ops < 64) op_log[n_ops] = {mgmt_wr, mgmt_reg};
        n_ops++;
        repeat (LAT - 1) @(negedge clk);
        mgmt_rdata = '0;
        if (mgmt_wr) begin
          last_w[mgmt_reg] = mgmt_wdata;
          if (mgmt_reg == 5'd4) n_w4++;
          if (mgmt_reg == 5'd0 && mgmt_wdata == 16'h8000) n_w8000++;
          if (mgmt_reg == 5'd0 && mgmt_wdata == 16'h3300) n_w3300++;
        end else if (mgmt_reg == 5'd0) begin
          n_rst_reads++;
          mgmt_rdata = (n_rst_reads <= rst_busy_reads) ? 16'h8000 : 16'h0000;
        end else if (mgmt_reg == 5'd18) begin
          mgmt_rdata = m_irq;
        end else if (mgmt_reg == 5'd1) begin
          mgmt_rdata = (stat_reads == 0) ? m_caps : poll_seq[(stat_reads - 1) % 32];
          stat_reads++;
        end
        mgmt_ack = 1'b1;
        @(negedge clk);
        mgmt_ack = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      repeat (TICK_GAP - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic run_seq(input logic [4:0] addr, input int mid_start_at);
    int cyc;
    exp_addr = addr;
    @(negedge clk); phy_addr = addr; start = 1'b1;
    @(negedge clk); start = 1'b0; phy_addr = ~addr;
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (cyc == mid_start_at) start = 1'b1; else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    if (!done) chk("R10 done seen", 0, 1);
  endtask

  task automatic check_after(input string req, input logic s, input logic d, input logic f);
    logic s0, d0, f0;
    int ops0;
    chk({req, " speed"}, speed, s);
    chk({req, " duplex"}, duplex, d);
    chk({req, " failed"}, failed, f);
    s0 = speed; d0 = duplex; f0 = failed; ops0 = n_ops;
    repeat (3 * TICK_GAP) @(negedge clk);
    chk("R10 single done pulse", done_cnt, 1);
    chk("R10 outputs held", {speed, duplex, failed}, {s0, d0, f0});
    chk("R1 no access after done", n_ops, ops0);
    chk("R2 phy address", addr_err, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 reset speed", speed, 0);
    chk("R1 reset duplex", duplex, 0);
    chk("R1 reset failed", failed, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset req", mgmt_req, 0);
  endtask

  task automatic t_nominal();
    logic [5:0] exp_ops [0:9];
    clear_model();
    exp_ops = '{6'h20, 6'h00, 6'h00, 6'h12, 6'h33, 6'h01, 6'h24, 6'h20, 6'h01, 6'h01};
    poll_seq[0] = 16'h0000; poll_seq[1] = 16'h0020;
    run_seq(5'h0B, -1);
    chk("R5 access count", n_ops, 10);
    for (int i = 0; i < 10; i++) chk("R5 access order", op_log[i], exp_ops[i]);
    chk("R3 reset write", n_w8000, 1);
    chk("R3 reset reads", n_rst_reads, 2);
    chk("R5 mask value", last_w[19], MASK_EXP);
    chk("R6 adv all caps", last_w[4], 16'h03E1);
    chk("R5 restart value", last_w[0], 16'h1200);
    chk("R7 poll count", stat_reads - 1, 2);
    check_after("R10 nominal", 1, 1, 0);
  endtask

  task automatic t_caps_subset();
    clear_model();
    m_caps = 16'h5000; m_irq = 16'h0040; rst_busy_reads = 0;
    run_seq(5'h1F, -1);
    chk("R6 adv subset", last_w[4], 16'h0141);
    chk("R3 immediate clear reads", n_rst_reads, 1);
    check_after("R10 subset", 0, 1, 0);
  endtask

  task automatic t_reset_timeout();
    clear_model();
    rst_busy_reads = 1000;
    run_seq(5'h03, -1);
    chk("R4 reset read limit", n_rst_reads, 6);
    chk("R4 no adv write", n_w4, 0);
    chk("R4 no status read", stat_reads, 0);
    check_after("R4 timeout", 0, 0, 1);
  endtask

  task automatic t_remote_fault();
    clear_model();
    m_irq = 16'h0080;
    poll_seq[0] = 16'h0010; poll_seq[1] = 16'h0020;
    run_seq(5'h11, -1);
    chk("R8 fault restart", n_w3300, 1);
    chk("R8 last ctrl write", last_w[0], 16'h3300);
    check_after("R9 fault cleared", 1, 0, 0);
    clear_model();
    poll_seq[0] = 16'h0030;
    run_seq(5'h11, -1);
    chk("R8 no restart when complete", n_w3300, 0);
    check_after("R9 complete with fault", 1, 1, 1);
  endtask

  task automatic t_aneg_timeout();
    clear_model();
    m_irq = 16'h0080;
    for (int i = 0; i < 32; i++) poll_seq[i] = 16'h0000;
    run_seq(5'h07, -1);
    chk("R7 poll limit", stat_reads - 1, 20);
    chk("R7 no fault restart", n_w3300, 0);
    check_after("R7 timeout", 1, 0, 1);
  endtask

  task automatic t_busy_start();
    clear_model();
    rst_busy_reads = 2;
    run_seq(5'h15, 30);
    chk("R1 start ignored reset writes", n_w8000, 1);
    chk("R1 start ignored adv writes", n_w4, 1);
    check_after("R1 busy start", 1, 1, 0);
  endtask

  initial begin
    clear_model();
    exp_addr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_nominal();
    t_caps_subset();
    t_reset_timeout();
    t_remote_fault();
    t_aneg_timeout();
    t_busy_start();
    finish_run();
  end
endmodule